// File: doc/BRIEF.md
# I2C Master Clock Phase Generator with Stretch Tolerance

This block produces the serial clock for an I2C master. Two 8-bit count inputs set how long the clock stays low and how long it stays high. The block never drives the line high. It either pulls SCL low through an open-drain driver or lets it go, and it watches the real line level through a two-stage synchronizer.

Each phase is timed from the moment the line is seen at the new level. A slave that holds SCL low stretches the high phase to match, and a slow rising edge lengthens the period. No correction is made for either. Two single-cycle strobes mark the accepted rising edge and the start of each pull-low, so a bit-level sequencer can place SDA changes and samples on them. A flag shows when the block has let go of the line but something else is still holding it low.

Top module: `scl_pacer`

## Requirements
- R1: While reset is held, and afterwards until `en` is sampled high, `scl_drive_low`, `rise_strobe`, `fall_strobe` and `stretch_hold` are all 0.
- R2: In the first clock cycle of every pull-low, `fall_strobe` is 1 for exactly one cycle. The first pull-low begins on the first rising clock edge that samples `en` high.
- R3: The low-phase count starts only after the synchronized line level reads low. `scl_in` passes through two flops, and the count starts one edge after the second flop shows low. On a line that follows the driver with no delay, `scl_drive_low` therefore stays 1 for `low_cnt`+4 cycles.
- R4: Once the low count has run `low_cnt`+1 cycles, the block releases SCL (`scl_drive_low` = 0), whatever the line level is.
- R5: The high-phase count starts only once the synchronized line level reads high. `rise_strobe` is 1 for one cycle on the edge that starts it, which is 3 clock edges after `scl_in` goes high.
- R6: The high count runs `high_cnt`+1 cycles and the next pull-low then begins. With a line that follows the driver, the period from one `fall_strobe` to the next is `low_cnt`+`high_cnt`+8 cycles.
- R7: If a slave holds SCL low for S extra cycles after release, `rise_strobe` and every later event arrive exactly S cycles later. No high time is counted during the hold.
- R8: `stretch_hold` is 1 while the block has released SCL and the synchronized level is still low. It drops 2 cycles after the line goes high.
- R9: When `en` is 0, `scl_drive_low` is 0 in the same cycle. On the next edge the block returns to idle with its counter cleared. A later enable then repeats the R2 to R6 timing exactly.
- R10: A count value N gives N+1 cycles of phase time over the whole 8-bit range. Both limits 0 and 255 are included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run the clock generator; 0 releases the line and returns to idle |
| low_cnt | input | 8 | Low-phase count N (N+1 cycles) |
| high_cnt | input | 8 | High-phase count N (N+1 cycles) |
| scl_in | input | 1 | Raw SCL line level read back from the pad |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| rise_strobe | output | 1 | One-cycle pulse when the sensed rising edge is accepted |
| fall_strobe | output | 1 | One-cycle pulse as a pull-low begins |
| stretch_hold | output | 1 | Released but line still sensed low |

## Verification
Call E0 the edge that starts a pull-low. Counting the two synchronizer flops and the state register, `fall_strobe` is due at E0 and `rise_strobe` at E0+`low_cnt`+7+S. The next `fall_strobe` is due `low_cnt`+`high_cnt`+8+S cycles after E0, and `stretch_hold` drops at release+S+2. The driver task turns each run's settings into these absolute cycle numbers and queues them. A monitor samples on the falling clock edge and checks each strobe against the head of the queue, both its kind and its cycle. The monitor also flags any strobe that is not in the queue.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_LOW_WAIT  = 3'd1,
    PH_LOW_CNT   = 3'd2,
    PH_REL_WAIT  = 3'd3,
    PH_HIGH_CNT  = 3'd4
  } phase_e;

  localparam int unsigned ARITH_W = 16;

  // A phase programmed with value n ends on the cycle whose count equals n.
  function automatic logic count_hit(input logic [ARITH_W-1:0] cnt,
                                     input logic [ARITH_W-1:0] lim);
    return cnt == lim;
  endfunction

  function automatic logic [ARITH_W-1:0] count_step(input logic [ARITH_W-1:0] cnt);
    return cnt + 1'b1;
  endfunction

  function automatic logic is_pull_phase(input phase_e ph);
    return (ph == PH_LOW_WAIT) || (ph == PH_LOW_CNT);
  endfunction

endpackage

// File: rtl/scl_sync2.sv
module scl_sync2 #(
  parameter int unsigned STAGES    = 2,
  parameter bit          IDLE_LVL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= IDLE_LVL;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= IDLE_LVL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
  import scl_pacer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] lim,
  output logic [CNT_W-1:0] value,
  output logic             hit
);
  localparam int unsigned PADW = ARITH_W - CNT_W;

  logic [ARITH_W-1:0] wide_val;
  logic [ARITH_W-1:0] wide_lim;
  logic [ARITH_W-1:0] wide_nxt;

  assign wide_val = {{PADW{1'b0}}, value};
  assign wide_lim = {{PADW{1'b0}}, lim};
  assign wide_nxt = count_step(wide_val);
  assign hit      = count_hit(wide_val, wide_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (clr) value <= '0;
    else if (inc) value <= wide_nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_pacer_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   sensed_hi,
  input  logic   low_hit,
  input  logic   high_hit,
  output phase_e phase,
  output logic   ctr_clr,
  output logic   ctr_inc,
  output logic   rise_p,
  output logic   fall_p
);
  phase_e phase_nxt;
  logic   enter_low;
  logic   enter_high;

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:     if (en)         phase_nxt = PH_LOW_WAIT;
      PH_LOW_WAIT: if (!sensed_hi) phase_nxt = PH_LOW_CNT;
      PH_LOW_CNT:  if (low_hit)    phase_nxt = PH_REL_WAIT;
      PH_REL_WAIT: if (sensed_hi)  phase_nxt = PH_HIGH_CNT;
      PH_HIGH_CNT: if (high_hit)   phase_nxt = PH_LOW_WAIT;
      default:                     phase_nxt = PH_IDLE;
    endcase
    if (!en) phase_nxt = PH_IDLE;
  end

  assign enter_low  = (phase_nxt == PH_LOW_WAIT) && (phase != PH_LOW_WAIT);
  assign enter_high = (phase_nxt == PH_HIGH_CNT) && (phase == PH_REL_WAIT);
  assign ctr_clr    = (phase_nxt != phase);
  assign ctr_inc    = (phase == PH_LOW_CNT) || (phase == PH_HIGH_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      rise_p <= 1'b0;
      fall_p <= 1'b0;
    end else begin
      phase  <= phase_nxt;
      rise_p <= enter_high;
      fall_p <= enter_low;
    end
  end

  AST_LOW_WAITS_FOR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOW_WAIT && sensed_hi) |=> (phase != PH_LOW_CNT)); // R3
  AST_HIGH_WAITS_FOR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REL_WAIT && !sensed_hi) |=> (phase != PH_HIGH_CNT)); // R5
  AST_DISABLE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase == PH_IDLE)); // R9
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_p && fall_p)); // R2
  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_p |=> !rise_p); // R5
endmodule

// File: rtl/scl_pacer.sv
module scl_pacer
  import scl_pacer_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             rise_strobe,
  output logic             fall_strobe,
  output logic             stretch_hold
);
  phase_e           phase;
  logic             sensed_hi;
  logic             ctr_clr;
  logic             ctr_inc;
  logic [CNT_W-1:0] ctr_value;
  logic [CNT_W-1:0] active_lim;
  logic             ctr_hit;
  logic             low_hit;
  logic             high_hit;

  scl_sync2 #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (scl_in),
    .q_sync  (sensed_hi)
  );

  // One counter serves both phases; the limit follows the phase.
  assign active_lim = (phase == PH_HIGH_CNT) ? high_cnt : low_cnt;

  scl_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctr_clr),
    .inc   (ctr_inc),
    .lim   (active_lim),
    .value (ctr_value),
    .hit   (ctr_hit)
  );

  assign low_hit  = ctr_hit && (phase == PH_LOW_CNT);
  assign high_hit = ctr_hit && (phase == PH_HIGH_CNT);

  scl_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .sensed_hi (sensed_hi),
    .low_hit   (low_hit),
    .high_hit  (high_hit),
    .phase     (phase),
    .ctr_clr   (ctr_clr),
    .ctr_inc   (ctr_inc),
    .rise_p    (rise_strobe),
    .fall_p    (fall_strobe)
  );

  assign scl_drive_low = en && is_pull_phase(phase);
  assign stretch_hold  = en && (phase == PH_REL_WAIT) && !sensed_hi;

  AST_RELEASE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (low_hit && en) |=> !scl_drive_low); // R4
  AST_NO_COUNT_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_hold |-> (ctr_value == '0)); // R7
  AST_HOLD_NOT_PULLING: assert property (@(posedge clk) disable iff (!rst_n)
    !(stretch_hold && scl_drive_low)); // R8
  AST_FALL_STARTS_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_strobe && en) |-> scl_drive_low); // R2
  always_comb begin
    if (!en) AST_DISABLE_RELEASES: assert (!scl_drive_low); // R9
  end
endmodule

// File: tb/tb_scl_pacer.sv
module tb_scl_pacer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] low_cnt = 8'd0;
  logic [7:0] high_cnt = 8'd0;
  logic       slave_hold = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, rise_strobe, fall_strobe, stretch_hold;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    bit    is_rise;
    int    at;
    string req;
  } evt_t;
  evt_t expq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Open-drain line: low if the master or the slave pulls it.
  assign scl_in = !(scl_drive_low || slave_hold);

  scl_pacer dut (
    .clk(clk), .rst_n(rst_n), .en(en), .low_cnt(low_cnt), .high_cnt(high_cnt),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .rise_strobe(rise_strobe),
    .fall_strobe(fall_strobe), .stretch_hold(stretch_hold)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  // Monitor: pops the scoreboard as strobes appear.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rise_strobe || fall_strobe) begin
        if (expq.size() == 0) begin
          n_vec++; n_bad++;
          $display("FAIL R2 unexpected strobe: got rise=%0d fall=%0d expected none (cycle %0d)",
                   rise_strobe, fall_strobe, cyc);
        end else begin
          evt_t e;
          e = expq.pop_front();
          chk(e.req, "strobe kind is_rise", int'(rise_strobe), int'(e.is_rise));
          chk(e.req, "strobe cycle", cyc, e.at);
        end
      end
    end
  end

  // Driver: one enable run of n periods, slave holding s cycles after the first release.
  task automatic run(input int l, input int h, input int n, input int s, input string tag);
    int e0, p, rel, last_fall;
    @(negedge clk);
    low_cnt = l[7:0];
    high_cnt = h[7:0];
    e0 = cyc + 1;
    p = l + h + 8;
    rel = e0 + l + 4;
    for (int k = 0; k < n; k++) begin
      expq.push_back('{1'b0, e0 + k*p + ((k == 0) ? 0 : s), (k == 0) ? "R2" : "R6"});
      expq.push_back('{1'b1, e0 + k*p + l + 7 + s, (s > 0) ? "R7" : tag});
    end
    last_fall = e0 + n*p + s;
    expq.push_back('{1'b0, last_fall, (s > 0) ? "R7" : "R6"});
    en = 1'b1;
    while (cyc < last_fall + 1) begin
      @(negedge clk);
      if (cyc == e0 + 2) chk("R3", "drive low early in low phase", int'(scl_drive_low), 1);
      if (cyc == rel - 1) chk("R3", "drive low at last low cycle", int'(scl_drive_low), 1);
      if (cyc == rel) chk("R4", "released after low count", int'(scl_drive_low), 0);
      if (s > 0) begin
        if (cyc == e0 + 1) slave_hold = 1'b1;
        if (cyc == rel + s/2) chk("R8", "stretch flag during hold", int'(stretch_hold), 1);
        if (cyc == rel + s/2) chk("R7", "still released during hold", int'(scl_drive_low), 0);
        if (cyc == rel + s) slave_hold = 1'b0;
        if (cyc == rel + s + 2) chk("R8", "stretch flag after line high", int'(stretch_hold), 0);
      end
    end
    en = 1'b0;
    #1;
    chk("R9", "drive released with enable low", int'(scl_drive_low), 0);
    repeat (10) @(negedge clk);
    chk("R9", "all expected strobes seen", expq.size(), 0);
    chk("R9", "idle stretch flag", int'(stretch_hold), 0);
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset drive", int'(scl_drive_low), 0);
    chk("R1", "reset flags", int'(rise_strobe | fall_strobe | stretch_hold), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "idle after reset drive", int'(scl_drive_low), 0);
    chk("R1", "idle after reset strobes", int'(rise_strobe | fall_strobe), 0);
    run(5, 3, 3, 0, "R5");
    run(0, 0, 3, 0, "R10");
    run(9, 14, 2, 0, "R5");
    run(4, 2, 2, 20, "R7");
    run(255, 255, 1, 0, "R10");
    run(1, 200, 1, 0, "R10");
    run(5, 3, 2, 0, "R9");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL R1 watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule